// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block collects the interrupt sources of a DMA event channel into one level-sensitive interrupt line. The engine drives one single-cycle pulse per source. Each pulse sets a sticky bit in a status register. An enable register masks the status bits. The interrupt line is raised while any enabled status bit is set and the delivery-mode field selects level delivery. Software reads the status register to find the cause. It then clears the bits it has handled by writing ones to a separate clear register.

Six source positions are implemented:

| Bit | Source |
| --- | --- |
| 0 | end-of-block completion |
| 1 | event write-response error |
| 9 | descriptor read-response error |
| 10 | data read error |
| 11 | data write error |
| 14 | invalid descriptor |

Every implemented position except bit 0 belongs to the error class. A separate output flags that an enabled error-class bit is pending, so that the channel can be sent into recovery. Both outputs are registered and follow the register state that is in force after each clock edge.

Register access uses a plain word bus. A write completes at the clock edge on which the write strobe is high. A read strobe captures the addressed register into `reg_rdata` at its edge, and the data holds there until the next read.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous reset, the status, enable and mode registers read as 0, and `irq` and `err` are low.
- R2: A pulse on `src_pulse[i]` sets status bit i at that edge, for i in {0,1,9,10,11,14}. Status is read at offset 0x100. Pulses on every other position are ignored, and those bits read as 0.
- R3: A write to offset 0x108 clears each status bit whose written data bit is 1. Bits written with 0 keep their value.
- R4: A pulse on a source in the same cycle as a clear of that bit wins, so the bit stays set.
- R5: The enable register at offset 0x110 is read/write on the implemented positions (mask 0x4E03). Its other bits read as 0.
- R6: After each edge, `irq` is 1 exactly when the mode field equals 1 and (status AND enable) is nonzero.
- R7: Writing 0 to the enable register drops `irq` and `err` but leaves the status bits latched. Re-enabling raises `irq` again.
- R8: After each edge, `err` is 1 exactly when (status AND enable AND 0x4E02) is nonzero. Bit 0 alone never raises `err`, and the mode field has no effect on `err`.
- R9: The mode register at offset 0x004 stores write-data bits 3:0, and its upper bits read as 0. Only the value 1 enables `irq`.
- R10: Writes to offset 0x100 are ignored. Reads of offset 0x108 and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (12) | Byte offset of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| src_pulse | input | 16 | One pulse per source position |
| irq | output | 1 | Level interrupt output |
| err | output | 1 | Error-class pending, recovery needed |

## Verification
The bench builds the block with the default 32-bit data and 12-bit address widths. At these widths all 16 source positions, all 16 mode values and every single-bit enable can be swept one by one. For each pattern the bench computes the expected status, interrupt and error values from the implemented and error masks. Directed cases cover a clear that coincides with a pulse, masking through the enable register with the status kept latched, writes to the read-only status offset, and reads of unmapped offsets.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;
  localparam int IRQ_W  = 16;
  localparam int MODE_W = 4;

  // source bit positions
  localparam int BIT_EOB     = 0;
  localparam int BIT_EV_WR   = 1;
  localparam int BIT_DESC_RD = 9;
  localparam int BIT_DAT_RD  = 10;
  localparam int BIT_DAT_WR  = 11;
  localparam int BIT_BAD_DSC = 14;

  localparam logic [IRQ_W-1:0] SRC_ERR =
    IRQ_W'((1 << BIT_EV_WR) | (1 << BIT_DESC_RD) | (1 << BIT_DAT_RD) |
           (1 << BIT_DAT_WR) | (1 << BIT_BAD_DSC));
  localparam logic [IRQ_W-1:0] SRC_IMPL = SRC_ERR | IRQ_W'(1 << BIT_EOB);

  localparam int OFF_MODE = 'h004;
  localparam int OFF_STS  = 'h100;
  localparam int OFF_CLR  = 'h108;
  localparam int OFF_EN   = 'h110;

  localparam logic [MODE_W-1:0] MODE_LEVEL = MODE_W'(1);
endpackage

// File: rtl/dma_irq_agg_decode.sv
module dma_irq_agg_decode
  import dma_irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [IRQ_W-1:0]  sts_q,
  input  logic [IRQ_W-1:0]  en_q,
  input  logic [MODE_W-1:0] mode_q,
  output logic              we_mode,
  output logic              we_en,
  output logic              we_clr,
  output logic [DATA_W-1:0] rdata
);
  logic hit_mode, hit_sts, hit_en;
  logic [DATA_W-1:0] rd_mux;

  assign hit_mode = (reg_addr == ADDR_W'(OFF_MODE));
  assign hit_sts  = (reg_addr == ADDR_W'(OFF_STS));
  assign hit_en   = (reg_addr == ADDR_W'(OFF_EN));

  assign we_mode = reg_wr && hit_mode;
  assign we_en   = reg_wr && hit_en;
  assign we_clr  = reg_wr && (reg_addr == ADDR_W'(OFF_CLR));

  always_comb begin
    rd_mux = '0;
    if (hit_mode)     rd_mux = DATA_W'(mode_q);
    else if (hit_sts) rd_mux = DATA_W'(sts_q);
    else if (hit_en)  rd_mux = DATA_W'(en_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (reg_rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_irq_agg_status.sv
module dma_irq_agg_status
  import dma_irq_agg_pkg::*;
#(
  parameter int W = IRQ_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pulse,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] sts_d,
  output logic [W-1:0] sts_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (SRC_IMPL[i]) begin : g_impl
      // a pulse beats a clear in the same cycle
      assign sts_d[i] = pulse[i] | (sts_q[i] & ~(clr_we & clr_bits[i]));
      always_ff @(posedge clk) begin
        if (rst) sts_q[i] <= 1'b0;
        else     sts_q[i] <= sts_d[i];
      end
    end else begin : g_none
      assign sts_d[i] = 1'b0;
      assign sts_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_agg_out.sv
module dma_irq_agg_out
  import dma_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IRQ_W-1:0]  sts_d,
  input  logic [IRQ_W-1:0]  en_d,
  input  logic [MODE_W-1:0] mode_d,
  output logic              irq,
  output logic              err
);
  logic [IRQ_W-1:0] cause_d;
  assign cause_d = sts_d & en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      err <= 1'b0;
    end else begin
      irq <= (mode_d == MODE_LEVEL) && (|cause_d);
      err <= |(cause_d & SRC_ERR);
    end
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [IRQ_W-1:0]  src_pulse,
  output logic              irq,
  output logic              err
);
  logic we_mode, we_en, we_clr;
  logic [IRQ_W-1:0]  sts_d, sts_q, en_d, en_q;
  logic [MODE_W-1:0] mode_d, mode_q;

  dma_irq_agg_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .sts_q(sts_q), .en_q(en_q), .mode_q(mode_q),
    .we_mode(we_mode), .we_en(we_en), .we_clr(we_clr), .rdata(reg_rdata)
  );

  dma_irq_agg_status #(.W(IRQ_W)) u_sts (
    .clk(clk), .rst(rst), .pulse(src_pulse), .clr_we(we_clr),
    .clr_bits(reg_wdata[IRQ_W-1:0]), .sts_d(sts_d), .sts_q(sts_q)
  );

  assign en_d   = we_en   ? (reg_wdata[IRQ_W-1:0] & SRC_IMPL) : en_q;
  assign mode_d = we_mode ? reg_wdata[MODE_W-1:0] : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

  dma_irq_agg_out u_out (
    .clk(clk), .rst(rst), .sts_d(sts_d), .en_d(en_d), .mode_d(mode_d),
    .irq(irq), .err(err)
  );
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk
  import dma_irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [IRQ_W-1:0]  src_pulse,
  input logic [IRQ_W-1:0]  sts_q,
  input logic [IRQ_W-1:0]  en_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              irq,
  input logic              err
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !err && sts_q == '0));

  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_q & ~SRC_IMPL) == '0);

  // R4
  pulse_sets_chk: assert property (@(posedge clk) disable iff (rst)
    |(src_pulse & SRC_IMPL) |=>
      ((sts_q & $past(src_pulse) & SRC_IMPL) == ($past(src_pulse) & SRC_IMPL)));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mode_q == MODE_LEVEL && |(sts_q & en_q)));

  // R7
  mask_keeps_sts_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFF_EN)) |=>
      ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> |(sts_q & en_q & SRC_ERR));
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .src_pulse(src_pulse), .sts_q(sts_q), .en_q(en_q), .mode_q(mode_q),
  .irq(irq), .err(err)
);

// File: tb/test_dma_irq_agg.sv
`timescale 1ns/1ps
module test_dma_irq_agg;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [15:0] IMPL = 16'h4E03;
  localparam logic [15:0] ERRM = 16'h4E02;
  localparam logic [AW-1:0] A_MODE = 12'h004, A_STS = 12'h100,
                            A_CLR = 12'h108, A_EN = 12'h110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [15:0] src_pulse = '0;
  logic irq, err;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_irq_agg i_dma_irq_agg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_pulse(src_pulse), .irq(irq), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk);
    src_pulse = v;
    @(negedge clk);
    src_pulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 err", err, 0);
    rd(A_STS, d);  check("R1 status", d, 0);
    rd(A_EN, d);   check("R1 enable", d, 0);
    rd(A_MODE, d); check("R1 mode", d, 0);

    // R9 mode field width
    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, d); check("R9 mode upper bits", d, 32'hF);
    wr(A_MODE, 32'h1);
    rd(A_MODE, d); check("R9 mode readback", d, 32'h1);

    // R5 enable sweep over every single bit
    for (int b = 0; b < 32; b++) begin
      wr(A_EN, 32'h1 << b);
      rd(A_EN, d);
      check("R5 enable bit", d, (32'h1 << b) & {16'h0, IMPL});
    end
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R5 enable all", d, {16'h0, IMPL});

    // R2 R6 R8 pulse sweep on every source position
    for (int b = 0; b < 16; b++) begin
      logic [15:0] m;
      m = 16'h1 << b;
      wr(A_CLR, 32'hFFFF);
      check("R3 cleared irq", irq, 0);
      pulse(m);
      check("R6 irq per source", irq, |(m & IMPL));
      check("R8 err per source", err, |(m & ERRM));
      rd(A_STS, d);
      check("R2 status per source", d, {16'h0, m & IMPL});
    end

    // R7 masking keeps status
    wr(A_CLR, 32'hFFFF);
    pulse(16'h0400);
    check("R7 irq before mask", irq, 1);
    wr(A_EN, 32'h0);
    check("R7 irq masked", irq, 0);
    check("R7 err masked", err, 0);
    rd(A_STS, d); check("R7 status latched", d, 32'h0400);
    wr(A_EN, 32'hFFFF);
    check("R7 irq re-enabled", irq, 1);

    // R3 selective clear
    wr(A_CLR, 32'hFFFF);
    pulse(16'h4201);
    rd(A_STS, d); check("R3 set three", d, 32'h4201);
    wr(A_CLR, 32'h0200);
    rd(A_STS, d); check("R3 clear one", d, 32'h4001);
    wr(A_CLR, 32'h0);
    rd(A_STS, d); check("R3 zero write", d, 32'h4001);
    wr(A_CLR, 32'h4000);
    check("R8 eob only no err", err, 0);
    check("R6 eob only irq", irq, 1);

    // R4 pulse vs clear collision
    pulse(16'h0002);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h0203;
    src_pulse = 16'h0200;
    @(negedge clk);
    reg_wr = 1'b0; src_pulse = '0;
    rd(A_STS, d); check("R4 pulse wins clear", d, 32'h0200);

    // R9 R8 mode sweep with an error bit pending
    for (int m = 0; m < 16; m++) begin
      wr(A_MODE, 32'(m));
      check("R9 irq per mode", irq, (m == 1));
      check("R8 err ignores mode", err, 1);
    end
    wr(A_MODE, 32'h1);

    // R10 read-only status and unmapped reads
    wr(A_STS, 32'hFFFF);
    rd(A_STS, d); check("R10 status write ignored", d, 32'h0200);
    rd(A_CLR, d); check("R10 clear reads zero", d, 0);
    rd(12'h104, d); check("R10 unmapped 0x104", d, 0);
    rd(12'h200, d); check("R10 unmapped 0x200", d, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule